// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel bytes into asynchronous serial frames. Software or a neighbouring engine writes a byte into a holding register. When the shift register is free and a bit tick arrives from an external baud generator, the byte moves across and goes out on the serial line. The frame is a low start bit, the data bits least significant first, and a high stop bit.

An optional ninth data bit, captured with the write, can be inserted between the last data bit and the stop bit. This bit can carry an address/data marker or a parity bit that is computed elsewhere. Two registers sit in series, so a second byte can be written while the first is still being shifted out. The second frame then follows without a gap.

Two flags report the state of the block. One shows that the holding register can accept a byte, and it drives a maskable interrupt. The other shows that the shifter has no frame in progress. Frames run only while both the transmit enable and the port enable are high.

Top module: `sertx_top`

## Requirements
- R1: In 8-bit mode a frame is a 0 start bit, then data bits 0 through 7 in that order, then a 1 stop bit (10 bits). Each bit appears on `tx_line` in the cycle after the `bit_tick` that starts it, and it holds until the next tick.
- R2: When `nine_en` is 1 at transfer, the value of `wr_bit9` captured with the write is sent after data bit 7 and before the stop bit (11 bits).
- R3: A write into an empty holding register is accepted, and `hold_empty` goes low in the cycle after the write strobe.
- R4: A held byte moves to the shift register on the first `bit_tick` that finds the shifter empty or finishing its stop bit. In the following cycle `hold_empty` is 1 and `tx_line` shows the start bit.
- R5: If the holding register is full when a stop bit completes, the next start bit follows on that same tick with no idle bit between the frames.
- R6: `shift_empty` is 1 while no frame is in progress. It is 0 from the transfer tick until the tick that ends the stop bit.
- R7: Frames start or advance only while `tx_en` and `port_en` are both 1. Clearing either of them abandons the current frame in the next cycle (`shift_empty` 1, `tx_line` 1) and leaves a held byte in place.
- R8: `irq` equals `hold_empty` AND `irq_en`.
- R9: A write while the holding register is full is ignored, and the held byte is the one that is sent.
- R10: After reset `tx_line` is 1, `hold_empty` is 1 and `shift_empty` is 1.
- R11: `tx_line` stays at 1 whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period from the baud generator |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| wr_bit9 | input | 1 | Ninth data bit, captured with the write |
| nine_en | input | 1 | Selects 9-bit frames |
| tx_en | input | 1 | Transmit enable |
| port_en | input | 1 | Serial port enable |
| irq_en | input | 1 | Interrupt enable |
| tx_line | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a byte |
| irq | output | 1 | Holding-empty interrupt |
| shift_empty | output | 1 | No frame in progress |

## Verification
The bench builds the block with the default `DATA_W` of 8 and switches `nine_en` between frames, so both the 10-bit and the 11-bit layouts, with the ninth bit at 0 and at 1, are covered. The bench drives `bit_tick` directly instead of through a divider. Every bit boundary, the stop-to-start handover between back-to-back frames, and an abort in mid-frame therefore each take only a few cycles to reach.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_BUSY = 1'b1
  } sh_state_e;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              take,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_bit9
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              b9_q, b9_d;
  logic              accept;

  always_comb begin
    accept = wr_en & ~full_q;
    full_d = full_q;
    data_d = data_q;
    b9_d   = b9_q;
    if (take)
      full_d = 1'b0;
    if (accept) begin
      full_d = 1'b1;
      data_d = wr_data;
      b9_d   = wr_bit9;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      b9_q   <= 1'b0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
      b9_q   <= b9_d;
    end
  end

  assign hold_full = full_q;
  assign hold_data = data_q;
  assign hold_bit9 = b9_q;

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !take) |=> hold_full); // R9
  AST_HELD_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !take) |=> $stable(hold_data)); // R9
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              active,
  input  logic              nine_en,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_bit9,
  output logic              take,
  output logic              busy,
  output logic              line
);
  localparam int SH_W  = DATA_W + 2;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] LEFT_8 = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] LEFT_9 = CNT_W'(DATA_W + 2);

  sh_state_e        state_q, state_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             line_q, line_d;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    left_d  = left_q;
    line_d  = line_q;
    take    = 1'b0;
    if (!active) begin
      state_d = SH_IDLE;
      left_d  = '0;
      line_d  = 1'b1;
    end else if (bit_tick) begin
      if (state_q == SH_BUSY && left_q != '0) begin
        line_d = sh_q[0];
        sh_d   = {1'b1, sh_q[SH_W-1:1]};
        left_d = left_q - CNT_W'(1);
      end else if (hold_full) begin
        take    = 1'b1;
        state_d = SH_BUSY;
        line_d  = 1'b0;
        sh_d    = {1'b1, (nine_en ? hold_bit9 : 1'b1), hold_data};
        left_d  = nine_en ? LEFT_9 : LEFT_8;
      end else begin
        state_d = SH_IDLE;
        line_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      sh_q    <= '1;
      left_q  <= '0;
      line_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      left_q  <= left_d;
      line_q  <= line_d;
    end
  end

  assign busy = (state_q == SH_BUSY);
  assign line = line_q;

  AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bit_tick && hold_full)); // R4
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !line); // R1
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left_q == '0) |-> line); // R1
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line); // R11
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              nine_en,
  input  logic              tx_en,
  input  logic              port_en,
  input  logic              irq_en,
  output logic              tx_line,
  output logic              hold_empty,
  output logic              irq,
  output logic              shift_empty
);
  logic              take;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              hold_bit9;
  logic              busy;
  logic              active;

  assign active = tx_en & port_en;

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_bit9   (wr_bit9),
    .take      (take),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .hold_bit9 (hold_bit9)
  );

  sertx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .active    (active),
    .nine_en   (nine_en),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .hold_bit9 (hold_bit9),
    .take      (take),
    .busy      (busy),
    .line      (tx_line)
  );

  assign hold_empty  = ~hold_full;
  assign shift_empty = ~busy;
  assign irq         = hold_empty & irq_en;

  AST_INACTIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && port_en) |=> (shift_empty && tx_line)); // R7
endmodule

// File: tb/sertx_top_test.sv
`timescale 1ns/1ps
module sertx_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_bit9 = 1'b0;
  logic       nine_en = 1'b0;
  logic       tx_en = 1'b0;
  logic       port_en = 1'b0;
  logic       irq_en = 1'b0;
  logic       tx_line, hold_empty, irq, shift_empty;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sertx_top #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_data(wr_data), .wr_bit9(wr_bit9), .nine_en(nine_en), .tx_en(tx_en),
    .port_en(port_en), .irq_en(irq_en), .tx_line(tx_line),
    .hold_empty(hold_empty), .irq(irq), .shift_empty(shift_empty)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic write(input logic [7:0] d, input logic b9);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_bit9 = b9;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Start bit already on the line; check data, optional ninth bit and stop.
  task automatic frame_body(input logic [7:0] d, input logic nine, input logic b9);
    for (int i = 0; i < 8; i++) begin
      tick();
      chk("R1", $sformatf("data bit %0d", i), tx_line, d[i]);
    end
    if (nine) begin
      tick();
      chk("R2", "ninth bit", tx_line, b9);
    end
    tick();
    chk("R1", "stop bit", tx_line, 1'b1);
    chk("R6", "busy during stop", shift_empty, 1'b0);
  endtask

  task automatic t_reset();
    chk("R10", "line after reset", tx_line, 1'b1);
    chk("R10", "hold_empty after reset", hold_empty, 1'b1);
    chk("R10", "shift_empty after reset", shift_empty, 1'b1);
    chk("R8", "irq masked", irq, 1'b0);
  endtask

  task automatic t_single(input logic [7:0] d, input logic nine, input logic b9);
    nine_en = nine;
    write(d, b9);
    chk("R3", "hold_empty after write", hold_empty, 1'b0);
    chk("R6", "shift idle before tick", shift_empty, 1'b1);
    chk("R11", "idle line before tick", tx_line, 1'b1);
    tick();
    chk("R4", "start bit", tx_line, 1'b0);
    chk("R4", "hold_empty after transfer", hold_empty, 1'b1);
    chk("R6", "shift busy", shift_empty, 1'b0);
    frame_body(d, nine, b9);
    tick();
    chk("R6", "shift empty after frame", shift_empty, 1'b1);
    chk("R11", "idle line after frame", tx_line, 1'b1);
    tick();
    chk("R11", "line stays idle", tx_line, 1'b1);
  endtask

  task automatic t_back_to_back();
    nine_en = 1'b0;
    write(8'h96, 1'b0);
    tick();
    chk("R4", "first start bit", tx_line, 1'b0);
    write(8'h4E, 1'b0);
    chk("R3", "second byte accepted", hold_empty, 1'b0);
    write(8'hFF, 1'b0);
    chk("R9", "still full after ignored write", hold_empty, 1'b0);
    frame_body(8'h96, 1'b0, 1'b0);
    tick();
    chk("R5", "next start with no gap", tx_line, 1'b0);
    chk("R5", "shifter stays busy", shift_empty, 1'b0);
    chk("R4", "holding freed on handover", hold_empty, 1'b1);
    frame_body(8'h4E, 1'b0, 1'b0); // R9: the ignored 0xFF must not appear
    tick();
    chk("R6", "empty after second frame", shift_empty, 1'b1);
  endtask

  task automatic t_enables();
    nine_en = 1'b0;
    tx_en = 1'b0;
    write(8'h0F, 1'b0);
    tick();
    tick();
    chk("R7", "no start with tx_en low", tx_line, 1'b1);
    chk("R7", "shifter idle with tx_en low", shift_empty, 1'b1);
    chk("R7", "byte kept while disabled", hold_empty, 1'b0);
    tx_en = 1'b1;
    port_en = 1'b0;
    tick();
    chk("R7", "no start with port_en low", shift_empty, 1'b1);
    port_en = 1'b1;
    tick();
    chk("R7", "start once both enabled", tx_line, 1'b0);
    tick();
    chk("R1", "bit 0 before abort", tx_line, 1'b1);
    @(negedge clk) port_en = 1'b0;
    @(negedge clk);
    chk("R7", "abort frees shifter", shift_empty, 1'b1);
    chk("R7", "abort returns line high", tx_line, 1'b1);
    port_en = 1'b1;
    tick();
    chk("R11", "idle after abort", tx_line, 1'b1);
  endtask

  task automatic t_irq();
    irq_en = 1'b1;
    @(negedge clk);
    chk("R8", "irq when empty and enabled", irq, 1'b1);
    write(8'h55, 1'b0);
    chk("R8", "irq low when full", irq, 1'b0);
    irq_en = 1'b0;
    tick();
    @(negedge clk);
    chk("R8", "irq masked when empty", irq, 1'b0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R8", "irq back after unmask", irq, 1'b1);
    frame_body(8'h55, 1'b0, 1'b0);
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    tx_en = 1'b1;
    port_en = 1'b1;
    t_single(8'hA5, 1'b0, 1'b0);
    t_single(8'h3C, 1'b1, 1'b1);
    t_single(8'hC3, 1'b1, 1'b0);
    t_back_to_back();
    t_enables();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule